// File: doc/BRIEF.md
# Base-Delta Cache Line Decompressor

This block turns a compressed cache line back into its 32-byte form. A compressed line has three parts. The first is a 4-bit encoding code. The second is a payload that holds a base value followed by packed deltas. The third is a per-element mask that picks, for each element, either the stored base or an implicit base of zero.

Every element is rebuilt at the same time. The block sign-extends each delta and adds the selected base to it, so the whole line comes out of one wide vector addition with no serial chain. The same block also expands the all-zero and repeated-value encodings, and it passes uncompressed lines through unchanged.

A cache read path hands the block a compressed line over a valid/ready handshake. The rebuilt line leaves over a second valid/ready handshake exactly one cycle after it was accepted, whatever the encoding.

Top module: `bdi_line_decomp`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A line accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_line`, with `out_valid` high, after that edge. This latency is the same for every code. `out_valid` falls after an edge where `out_ready` is high and nothing new is accepted.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_line` holds its value.
- R4: Code 0 (zero line) produces 32 zero bytes, whatever the payload and mask hold.
- R5: Code 1 (repeated value) copies payload bytes 0..7 into each of the four 8-byte elements.
- R6: Codes 2..7 select an (element bytes, delta bytes) pair: 2=(8,1), 3=(8,2), 4=(8,4), 5=(4,1), 6=(4,2), 7=(2,1). The base occupies payload bytes 0..E-1. Delta i occupies bytes E+i*D..E+i*D+D-1. Element i equals the base plus delta i sign-extended to E bytes.
- R7: When mask bit i is 1, element i is rebuilt from its sign-extended delta alone (zero base). Mask bits at or above the element count have no effect.
- R8: Code 8 and codes 9..15 pass the 32 payload bytes straight to `out_line`, and the mask is ignored.
- R9: The sum wraps modulo 2^(8*E). A carry or borrow never reaches the next element.
- R10: All values are little-endian. Payload byte k is `in_payload[8k+7:8k]`, and element i sits in `out_line` bytes i*E..i*E+E-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Compressed line offered |
| in_ready | output | 1 | Block can take a line this cycle |
| in_code | input | 4 | Encoding code |
| in_payload | input | 256 | Base and deltas, or raw/repeated data |
| in_zmask | input | 16 | Per-element zero-base select |
| out_valid | output | 1 | Rebuilt line present |
| out_ready | input | 1 | Consumer takes the line |
| out_line | output | 256 | Rebuilt 32-byte line |

## Verification
The bench uses negative deltas to expose a design that zero-extends deltas: such a design gives large positive elements where small or negative ones belong. It uses bases near the top of the range, where a sum that is not confined to its element carries into the next element. Lines that mix base-relative and zero-base elements, with junk in the unused high mask bits, show a mask applied to the wrong element or an element size that does not match the code. A stalled consumer, followed by a back-to-back transfer, shows a line that is overwritten while stalled or dropped when the stall releases.

// File: rtl/bdi_pkg.sv
package bdi_pkg;

    typedef enum logic [3:0] {
        CODE_ZERO = 4'd0,
        CODE_REP  = 4'd1,
        CODE_B8D1 = 4'd2,
        CODE_B8D2 = 4'd3,
        CODE_B8D4 = 4'd4,
        CODE_B4D1 = 4'd5,
        CODE_B4D2 = 4'd6,
        CODE_B2D1 = 4'd7,
        CODE_RAW  = 4'd8
    } bdi_code_e;

    typedef enum logic [1:0] {
        KIND_ZERO,
        KIND_REP,
        KIND_DELTA,
        KIND_RAW
    } bdi_kind_e;

    localparam int NUM_DELTA_FMT = 6;
    localparam int REP_BYTES     = 8;

    // element size of delta format k (k = code - 2)
    function automatic int fmt_elem_bytes(input int k);
        case (k)
            0, 1, 2: return 8;
            3, 4:    return 4;
            default: return 2;
        endcase
    endfunction

    // delta size of delta format k
    function automatic int fmt_delta_bytes(input int k);
        case (k)
            0, 3, 5: return 1;
            1, 4:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/bdi_code_decode.sv
module bdi_code_decode
    import bdi_pkg::*;
(
    input  logic [3:0]  code,
    output bdi_kind_e   kind,
    output logic [2:0]  fmt_sel
);
    always_comb begin
        kind    = KIND_RAW;
        fmt_sel = 3'd0;
        case (code)
            CODE_ZERO: kind = KIND_ZERO;
            CODE_REP:  kind = KIND_REP;
            CODE_B8D1, CODE_B8D2, CODE_B8D4,
            CODE_B4D1, CODE_B4D2, CODE_B2D1: begin
                kind    = KIND_DELTA;
                fmt_sel = 3'(code - 4'd2);
            end
            default:   kind = KIND_RAW;
        endcase
    end
endmodule

// File: rtl/bdi_delta_unpack.sv
module bdi_delta_unpack #(
    parameter int LINE_BYTES  = 32,
    parameter int ELEM_BYTES  = 8,
    parameter int DELTA_BYTES = 1,
    localparam int EW    = ELEM_BYTES * 8,
    localparam int DW    = DELTA_BYTES * 8,
    localparam int NELEM = LINE_BYTES / ELEM_BYTES,
    localparam int PAY_W = EW + NELEM * DW
) (
    input  logic [PAY_W-1:0]        payload,
    input  logic [NELEM-1:0]        zero_base,
    output logic [LINE_BYTES*8-1:0] line
);
    logic [EW-1:0] base_w;
    assign base_w = payload[EW-1:0];

    for (genvar g = 0; g < NELEM; g++) begin : g_elem
        logic [DW-1:0] delta_raw;
        logic [EW-1:0] delta_ext;
        logic [EW-1:0] addend;
        assign delta_raw = payload[EW + g*DW +: DW];
        assign delta_ext = {{(EW-DW){delta_raw[DW-1]}}, delta_raw};
        assign addend    = zero_base[g] ? '0 : base_w;
        assign line[g*EW +: EW] = addend + delta_ext;
    end
endmodule

// File: rtl/bdi_line_decomp.sv
module bdi_line_decomp
    import bdi_pkg::*;
#(
    parameter int LINE_BYTES = 32,
    localparam int LW     = LINE_BYTES * 8,
    localparam int MASK_W = LINE_BYTES / 2,
    localparam int NREP   = LINE_BYTES / REP_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [3:0]        in_code,
    input  logic [LW-1:0]     in_payload,
    input  logic [MASK_W-1:0] in_zmask,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [LW-1:0]     out_line
);
    typedef struct packed {
        logic          vld;
        logic [LW-1:0] line;
    } out_st_t;

    out_st_t st_d, st_q;

    bdi_kind_e  kind;
    logic [2:0] fmt_sel;
    logic [LW-1:0] cand [NUM_DELTA_FMT];
    logic [LW-1:0] built;
    logic          accept;

    bdi_code_decode u_dec (
        .code    (in_code),
        .kind    (kind),
        .fmt_sel (fmt_sel)
    );

    for (genvar k = 0; k < NUM_DELTA_FMT; k++) begin : g_fmt
        localparam int EB = fmt_elem_bytes(k);
        localparam int DB = fmt_delta_bytes(k);
        localparam int NE = LINE_BYTES / EB;
        localparam int PW = EB*8 + NE*DB*8;
        bdi_delta_unpack #(
            .LINE_BYTES  (LINE_BYTES),
            .ELEM_BYTES  (EB),
            .DELTA_BYTES (DB)
        ) u_unpack (
            .payload   (in_payload[PW-1:0]),
            .zero_base (in_zmask[NE-1:0]),
            .line      (cand[k])
        );
    end

    always_comb begin
        built = in_payload;
        case (kind)
            KIND_ZERO:  built = '0;
            KIND_REP:   for (int j = 0; j < NREP; j++)
                            built[j*REP_BYTES*8 +: REP_BYTES*8] = in_payload[REP_BYTES*8-1:0];
            KIND_DELTA: built = (int'(fmt_sel) < NUM_DELTA_FMT) ? cand[fmt_sel] : in_payload;
            default:    built = in_payload;
        endcase
    end

    assign in_ready = !st_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (out_ready) st_d.vld = 1'b0;
        if (accept) begin
            st_d.vld  = 1'b1;
            st_d.line = built;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_line  = st_q.line;

    assert_accept_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_line)));

    assert_stall_backpressure_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_zero_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_code == CODE_ZERO) |=> (out_line == '0));

    assert_raw_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_code >= CODE_RAW) |=> (out_line == $past(in_payload)));

endmodule

// File: tb/bdi_line_decomp_bench.sv
module bdi_line_decomp_bench;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         in_valid = 0;
    logic         in_ready;
    logic [3:0]   in_code = 0;
    logic [255:0] in_payload = '0;
    logic [15:0]  in_zmask = '0;
    logic         out_valid;
    logic         out_ready = 1;
    logic [255:0] out_line;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bdi_line_decomp u_bdi_line_decomp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .in_payload(in_payload), .in_zmask(in_zmask),
        .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line)
    );

    function automatic logic [255:0] model(input logic [3:0] code,
                                           input logic [255:0] pay,
                                           input logic [15:0] msk);
        logic [255:0] r;
        int eb, db;
        logic [63:0] base, d, s;
        r = pay;
        eb = 0; db = 0;
        case (code)
            4'd0: r = '0;
            4'd1: for (int j = 0; j < 4; j++) r[j*64 +: 64] = pay[63:0];
            4'd2: begin eb = 8; db = 1; end
            4'd3: begin eb = 8; db = 2; end
            4'd4: begin eb = 8; db = 4; end
            4'd5: begin eb = 4; db = 1; end
            4'd6: begin eb = 4; db = 2; end
            4'd7: begin eb = 2; db = 1; end
            default: r = pay;
        endcase
        if (eb != 0) begin
            base = '0;
            for (int b = 0; b < eb; b++) base[b*8 +: 8] = pay[b*8 +: 8];
            for (int i = 0; i < 32/eb; i++) begin
                d = '0;
                for (int b = 0; b < db; b++) d[b*8 +: 8] = pay[(eb + i*db + b)*8 +: 8];
                if (d[db*8-1]) for (int b = db; b < 8; b++) d[b*8 +: 8] = 8'hFF;
                s = (msk[i] ? 64'd0 : base) + d;
                for (int b = 0; b < eb; b++) r[(i*eb + b)*8 +: 8] = s[b*8 +: 8];
            end
        end
        return r;
    endfunction

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_line(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one transfer with out_ready high; checks timing and data
    task automatic xfer(input string req, input logic [3:0] code,
                        input logic [255:0] pay, input logic [15:0] msk,
                        input logic [255:0] exp);
        @(negedge clk);
        in_valid = 1; in_code = code; in_payload = pay; in_zmask = msk;
        @(negedge clk);
        in_valid = 0;
        chk_bit({req, " valid (R2)"}, out_valid, 1'b1);
        chk_line(req, out_line, exp);
    endtask

    task automatic test_reset;
        chk_bit("R1 out_valid", out_valid, 1'b0);
        chk_bit("R1 in_ready", in_ready, 1'b1);
    endtask

    task automatic test_zero;
        xfer("R4 zero line", 4'd0, {8{32'hDEADBEEF}}, 16'hFFFF, '0);
        @(negedge clk);
        chk_bit("R2 valid drops", out_valid, 1'b0);
    endtask

    task automatic test_repeat;
        logic [255:0] p;
        p = {192'h1111_2222_3333_4444_5555_6666_7777_8888_9999_AAAA_BBBB_CCCC, 64'h0123_4567_89AB_CDEF};
        xfer("R5 repeat", 4'd1, p, 16'h0, {4{64'h0123_4567_89AB_CDEF}});
    endtask

    task automatic test_delta_formats;
        logic [255:0] p;
        for (int c = 2; c <= 7; c++) begin
            for (int n = 0; n < 3; n++) begin
                p = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
                xfer("R6 R10 delta format", 4'(c), p, 16'h0, model(4'(c), p, 16'h0));
            end
        end
        // hand-built B8D1: base 0x100, deltas +1,-1,+0x7F,-0x80
        p = '0;
        p[63:0] = 64'h100;
        p[64 +: 32] = 32'h80_7F_FF_01;
        xfer("R6 B8D1 signed", 4'd2, p, 16'h0,
             {64'h80, 64'h17F, 64'hFF, 64'h101});
    endtask

    task automatic test_zero_base;
        logic [255:0] p;
        // B4D1 base 0x1000, deltas 1..8, mask elements 1,3,7 zero base, junk above bit 7
        p = '0;
        p[31:0] = 32'h1000;
        for (int i = 0; i < 8; i++) p[32 + i*8 +: 8] = 8'(i + 1);
        p[32 + 2*8 +: 8] = 8'hFE;
        xfer("R7 mixed zero base", 4'd5, p, 16'hFF8A, model(4'd5, p, 16'h008A));
        chk_line("R7 elem1 delta only", out_line[63:32], 32'h2);
        chk_line("R7 elem2 negative", out_line[95:64], 32'h0FFE);
        for (int c = 2; c <= 7; c++) begin
            p = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            xfer("R7 random mask", 4'(c), p, 16'hA5C3, model(4'(c), p, 16'hA5C3));
        end
    endtask

    task automatic test_wrap;
        logic [255:0] p;
        p = '0;
        p[31:0] = 32'hFFFF_FFFF;
        p[32 +: 8] = 8'h01;
        p[40 +: 8] = 8'h80;
        xfer("R9 wrap B4D1", 4'd5, p, 16'h0, model(4'd5, p, 16'h0));
        chk_line("R9 elem0 wraps to 0", out_line[31:0], 32'h0);
        chk_line("R9 no carry into elem1", out_line[63:32], 32'hFFFF_FF7F);
        p = '0;
        p[63:0] = 64'h0;
        p[64 +: 32] = 32'h8000_0000;
        xfer("R9 R6 B8D4 negative", 4'd4, p, 16'h0, model(4'd4, p, 16'h0));
        chk_line("R9 B8D4 elem0", out_line[63:0], 64'hFFFF_FFFF_8000_0000);
        p = '0;
        p[15:0] = 16'hFFFF;
        for (int i = 0; i < 16; i++) p[16 + i*8 +: 8] = 8'h01;
        xfer("R9 R10 B2D1 all wrap", 4'd7, p, 16'h0, '0);
    endtask

    task automatic test_raw;
        logic [255:0] p;
        for (int c = 8; c <= 15; c++) begin
            p = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            xfer("R8 passthrough", 4'(c), p, 16'hFFFF, p);
        end
    endtask

    task automatic test_stall;
        logic [255:0] pa, pb;
        pa = {8{32'hA5A5_0001}};
        pb = '0; pb[63:0] = 64'h55; pb[64 +: 8] = 8'h03;
        @(negedge clk);
        out_ready = 0;
        in_valid = 1; in_code = 4'd8; in_payload = pa; in_zmask = '0;
        @(negedge clk);
        in_code = 4'd2; in_payload = pb;
        chk_bit("R3 in_ready low", in_ready, 1'b0);
        repeat (2) @(negedge clk);
        chk_bit("R3 still valid", out_valid, 1'b1);
        chk_line("R3 line held", out_line, pa);
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        chk_line("R2 R3 next after stall", out_line, model(4'd2, pb, 16'h0));
        chk_bit("R2 valid after stall", out_valid, 1'b1);
        @(negedge clk);
        chk_bit("R2 drains", out_valid, 1'b0);
    endtask

    task automatic test_back_to_back;
        logic [255:0] p1, p2;
        p1 = {8{32'h0102_0304}};
        p2 = {8{32'h7F80_0011}};
        @(negedge clk);
        in_valid = 1; in_code = 4'd6; in_payload = p1; in_zmask = 16'h0;
        @(negedge clk);
        chk_line("R2 b2b first", out_line, model(4'd6, p1, 16'h0));
        in_code = 4'd3; in_payload = p2; in_zmask = 16'h0005;
        @(negedge clk);
        in_valid = 0;
        chk_line("R2 b2b second", out_line, model(4'd3, p2, 16'h0005));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1;
        @(negedge clk);
        test_reset();
        test_zero();
        test_repeat();
        test_delta_formats();
        test_zero_base();
        test_wrap();
        test_raw();
        test_stall();
        test_back_to_back();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule